// File: doc/BRIEF.md
# Write-Protect Command Detector

This block sits on the qualified write-event stream in front of a paged programming engine and adds software write protection. Each write event carries an address and a data byte. The block matches them against keyed address/data command sequences and decides, event by event, whether the write goes on to the engine as data, is held back as part of a command, or is swallowed and replaced by a dummy programming request.

A three-write unlock prefix lets the data that follows it through, even while protection is on. If nothing was protected before, the same prefix also arms protection. A six-write sequence arms the removal of protection. Command bytes never reach the engine. A new protect state takes effect only when the engine's next programming period ends, which is seen as a falling edge of its busy flag. When a sequence is followed by no data, the block requests a dummy period itself.

While protection is on, a write that has no prefix stores nothing but still requests a timed dummy period. The data window after a sequence, and any partly matched sequence, close after `GAP_LIMIT` cycles without an accepted write.

Top module: `wp_cmd_filter`

## Requirements
- R1: After reset, protectOn is 0. outValid and dummyReq are 0 while reset is held.
- R2: With protection off and no sequence in progress, a write (wrValid high, engineBusy low) that is not byte 0xAA at address 0x5555 appears on outAddr/outData with outValid one cycle later.
- R3: The enable sequence is data 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of its bytes appears on outValid.
- R4: After a completed sequence, protectOn changes only on the first falling edge of engineBusy after the data window has closed. It changes on the clock edge at which engineBusy is first seen low.
- R5: When the data window after a sequence closes (GAP_LIMIT cycles with no accepted write) and no data was accepted in it, dummyReq pulses for one cycle.
- R6: With protection on, a write that is not part of a sequence produces no outValid and exactly one dummyReq pulse, one cycle after the write.
- R7: With protection on, writes that follow the enable sequence inside its window pass to the output unchanged, and no dummy request is raised.
- R8: The disable sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. None of its bytes is passed. Protection turns off at the end of the next programming period.
- R9: A byte that breaks a sequence partway drops the bytes held so far. That byte is then handled as ordinary data: it is passed when protection is off and starts a dummy request when protection is on.
- R10: A gap of GAP_LIMIT cycles without an accepted write aborts a partial sequence. The next byte is then handled as ordinary data.
- R11: A write event that arrives while engineBusy is high produces no output and does not change the sequence state.
- R12: Command addresses are compared on bits 14:0 only. Higher address bits do not affect matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A qualified write event is present |
| wrAddr | input | ADDR_W | Write event address |
| wrData | input | 8 | Write event data |
| engineBusy | input | 1 | The programming engine is in a write period |
| outValid | output | 1 | A filtered write event is forwarded |
| outAddr | output | ADDR_W | Forwarded address |
| outData | output | 8 | Forwarded data |
| dummyReq | output | 1 | One-cycle request for a no-store programming period |
| protectOn | output | 1 | Software protection is active |

## Verification
The transition that is hardest to reach is a change of the protect state. It needs a full keyed sequence, a window that closes through the gap timer, and then a busy pulse from the engine, and the state has to stay unchanged at every point before that pulse falls. The bench plays the engine itself: it raises and drops engineBusy around each closed window and samples protectOn just before and just after the drop. For the compare width, it sweeps every combination of the address bits above bit 14 through full prefix-plus-data runs, and it breaks sequences both with a wrong byte and with a timed-out gap, with protection on and with it off.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  localparam int KEY_ADDR_BITS = 15;
  localparam int NUM_KEYS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_OFF3,
    ST_OFF4,
    ST_OFF5,
    ST_WINDOW
  } seqState_t;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_ON,
    PEND_OFF
  } pend_t;

  // strobes from control to datapath
  typedef struct packed {
    logic passWr;
    logic dummy;
  } ctrlStrobe_t;

  // key matches from datapath to control
  typedef struct packed {
    logic hitAa;
    logic hit55;
    logic hitA0;
    logic hit80;
    logic hit20;
  } keyHits_t;

  function automatic logic [KEY_ADDR_BITS-1:0] keyAddr(input int idx);
    return (idx == 1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] keyData(input int idx);
    case (idx)
      0: return 8'hAA;
      1: return 8'h55;
      2: return 8'hA0;
      3: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/wp_seq_datapath.sv
module wp_seq_datapath
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  ctrlStrobe_t       strobe,
  output keyHits_t          hits,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [7:0]        outData,
  output logic              dummyReq
);

  logic [NUM_KEYS-1:0] hitVec;

  for (genvar i = 0; i < NUM_KEYS; i++) begin : gKey
    assign hitVec[i] = (wrAddr[KEY_ADDR_BITS-1:0] == keyAddr(i)) &&
                       (wrData == keyData(i));
  end

  assign hits.hitAa = hitVec[0];
  assign hits.hit55 = hitVec[1];
  assign hits.hitA0 = hitVec[2];
  assign hits.hit80 = hitVec[3];
  assign hits.hit20 = hitVec[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outData  <= '0;
      dummyReq <= 1'b0;
    end else begin
      outValid <= strobe.passWr;
      dummyReq <= strobe.dummy;
      if (strobe.passWr) begin
        outAddr <= wrAddr;
        outData <= wrData;
      end
    end
  end

endmodule

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_seq_pkg::*;
#(
  parameter int GAP_LIMIT = 37500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        engineBusy,
  input  keyHits_t    hits,
  output ctrlStrobe_t strobe,
  output logic        protectOn
);

  localparam int CNT_W = $clog2(GAP_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_LIMIT - 1);

  seqState_t state, stateNext;
  pend_t     pend, pendNext;
  logic      dataSeen, dataSeenNext;
  logic      armed, armedNext;
  logic      busyPrev;
  logic [CNT_W-1:0] gapCnt;

  logic accept;
  logic timeout;
  logic busyFall;

  assign accept   = wrValid && !engineBusy;
  assign timeout  = (state != ST_IDLE) && !accept && (gapCnt == CNT_LAST);
  assign busyFall = busyPrev && !engineBusy;

  always_comb begin
    stateNext    = state;
    pendNext     = pend;
    dataSeenNext = dataSeen;
    armedNext    = armed;
    strobe       = '0;

    if (armed && busyFall) begin
      armedNext = 1'b0;
      pendNext  = PEND_NONE;
    end

    if (accept) begin
      unique case (state)
        ST_IDLE: begin
          if (hits.hitAa) stateNext = ST_KEY1;
          else begin
            strobe.passWr = !protectOn;
            strobe.dummy  = protectOn;
          end
        end
        ST_KEY1, ST_OFF4: begin
          if (hits.hit55) stateNext = (state == ST_KEY1) ? ST_KEY2 : ST_OFF5;
          else begin
            stateNext     = ST_IDLE;
            strobe.passWr = !protectOn;
            strobe.dummy  = protectOn;
          end
        end
        ST_KEY2: begin
          if (hits.hitA0) begin
            stateNext    = ST_WINDOW;
            pendNext     = protectOn ? PEND_NONE : PEND_ON;
            dataSeenNext = 1'b0;
            armedNext    = 1'b0;
          end else if (hits.hit80) begin
            stateNext = ST_OFF3;
          end else begin
            stateNext     = ST_IDLE;
            strobe.passWr = !protectOn;
            strobe.dummy  = protectOn;
          end
        end
        ST_OFF3: begin
          if (hits.hitAa) stateNext = ST_OFF4;
          else begin
            stateNext     = ST_IDLE;
            strobe.passWr = !protectOn;
            strobe.dummy  = protectOn;
          end
        end
        ST_OFF5: begin
          if (hits.hit20) begin
            stateNext    = ST_WINDOW;
            pendNext     = PEND_OFF;
            dataSeenNext = 1'b0;
            armedNext    = 1'b0;
          end else begin
            stateNext     = ST_IDLE;
            strobe.passWr = !protectOn;
            strobe.dummy  = protectOn;
          end
        end
        ST_WINDOW: begin
          strobe.passWr = 1'b1;
          dataSeenNext  = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end else if (timeout) begin
      stateNext = ST_IDLE;
      if (state == ST_WINDOW) begin
        strobe.dummy = !dataSeen;
        armedNext    = (pend != PEND_NONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pend      <= PEND_NONE;
      dataSeen  <= 1'b0;
      armed     <= 1'b0;
      busyPrev  <= 1'b0;
      gapCnt    <= '0;
      protectOn <= 1'b0;
    end else begin
      state    <= stateNext;
      pend     <= pendNext;
      dataSeen <= dataSeenNext;
      armed    <= armedNext;
      busyPrev <= engineBusy;
      if (accept || timeout || state == ST_IDLE) gapCnt <= '0;
      else gapCnt <= gapCnt + 1'b1;
      if (armed && busyFall) begin
        if (pend == PEND_ON) protectOn <= 1'b1;
        else if (pend == PEND_OFF) protectOn <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wp_cmd_filter.sv
module wp_cmd_filter
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int GAP_LIMIT = 37500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              engineBusy,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [7:0]        outData,
  output logic              dummyReq,
  output logic              protectOn
);

  ctrlStrobe_t strobe;
  keyHits_t    hits;

  wp_seq_ctrl #(.GAP_LIMIT(GAP_LIMIT)) ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .engineBusy(engineBusy),
    .hits(hits), .strobe(strobe), .protectOn(protectOn)
  );

  wp_seq_datapath #(.ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .hits(hits), .outValid(outValid), .outAddr(outAddr),
    .outData(outData), .dummyReq(dummyReq)
  );

endmodule

// File: rtl/wp_cmd_filter_chk.sv
module wp_cmd_filter_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              engineBusy,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [7:0]        outData,
  input logic              dummyReq,
  input logic              protectOn
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!protectOn && !outValid && !dummyReq)); // R1

  AST_FORWARD_FROM_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(wrValid) && !$past(engineBusy) &&
                  outAddr == $past(wrAddr) && outData == $past(wrData))); // R2

  AST_NO_PASS_AND_DUMMY: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && dummyReq)); // R6

  AST_PROTECT_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (protectOn != $past(protectOn)) |-> ($past(engineBusy, 2) && !$past(engineBusy))); // R4

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && engineBusy) |=> !outValid); // R11

endmodule

bind wp_cmd_filter wp_cmd_filter_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/wp_cmd_filter_test.sv
`timescale 1ns/1ps
module wp_cmd_filter_test;

  localparam int AW = 17;
  localparam int GAP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic engineBusy = 1'b0;
  logic outValid, dummyReq, protectOn;
  logic [AW-1:0] outAddr;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wp_cmd_filter #(.ADDR_W(AW), .GAP_LIMIT(GAP)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .engineBusy(engineBusy), .outValid(outValid),
    .outAddr(outAddr), .outData(outData), .dummyReq(dummyReq),
    .protectOn(protectOn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d,
                         input bit expPass, input bit expDummy, input string tag);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    check(outValid == expPass, {tag, " outValid"}, outValid, expPass);
    check(dummyReq == expDummy, {tag, " dummyReq"}, dummyReq, expDummy);
    if (expPass) begin
      check(outAddr == a, {tag, " outAddr"}, outAddr, a);
      check(outData == d, {tag, " outData"}, outData, d);
    end
  endtask

  task automatic idleWatch(input int n, input int expDummies, input string tag);
    int seen = 0;
    int passes = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dummyReq) seen++;
      if (outValid) passes++;
    end
    check(seen == expDummies, {tag, " dummy count"}, seen, expDummies);
    check(passes == 0, {tag, " stray output"}, passes, 0);
  endtask

  task automatic busyPulse(input bit expBefore, input bit expAfter, input string tag);
    @(negedge clk);
    engineBusy = 1'b1;
    repeat (3) @(negedge clk);
    check(protectOn == expBefore, {tag, " protect before fall"}, protectOn, expBefore);
    engineBusy = 1'b0;
    @(negedge clk);
    check(protectOn == expAfter, {tag, " protect after fall"}, protectOn, expAfter);
  endtask

  task automatic sendEnable(input logic [1:0] ub, input string tag);
    doWrite({ub, 15'h5555}, 8'hAA, 1'b0, 1'b0, tag);
    doWrite({ub, 15'h2AAA}, 8'h55, 1'b0, 1'b0, tag);
    doWrite({ub, 15'h5555}, 8'hA0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(protectOn == 1'b0, "R1 protect in reset", protectOn, 0);
    check(outValid == 1'b0 && dummyReq == 1'b0, "R1 outputs in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(protectOn == 1'b0, "R1 protect after reset", protectOn, 0);

    // R2 sweep of ordinary writes
    for (int i = 0; i < 16; i++)
      doWrite(AW'(i * 4099 + 3), 8'((i * 29) ^ 8'h3C), 1'b1, 1'b0, "R2 sweep");
    doWrite(17'h01234, 8'hAA, 1'b1, 1'b0, "R2 key data other addr");

    // R3 enable with no data, R5 dummy at window end, R4 timing
    sendEnable(2'd0, "R3 enable");
    idleWatch(GAP + 4, 1, "R5 empty window");
    check(protectOn == 1'b0, "R4 not yet on", protectOn, 0);
    busyPulse(1'b0, 1'b1, "R4 enable");

    // R6 unprefixed protected write
    doWrite(17'h00100, 8'h5A, 1'b0, 1'b1, "R6 protected write");

    // R11 write while busy
    @(negedge clk);
    engineBusy = 1'b1;
    doWrite(17'h00200, 8'h11, 1'b0, 1'b0, "R11 busy write");
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R11 busy key");
    engineBusy = 1'b0;
    @(negedge clk);
    doWrite(17'h02AAA, 8'h55, 1'b0, 1'b1, "R11 state unchanged");

    // R7 prefixed data while protected
    sendEnable(2'd0, "R7 prefix");
    doWrite(17'h00300, 8'h01, 1'b1, 1'b0, "R7 data");
    doWrite(17'h00301, 8'h02, 1'b1, 1'b0, "R7 data");
    doWrite(17'h05555, 8'hAA, 1'b1, 1'b0, "R7 key-like data");
    idleWatch(GAP + 4, 0, "R7 window");
    busyPulse(1'b1, 1'b1, "R7 stays on");

    // R9 mismatch while protected
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R9 held");
    doWrite(17'h00010, 8'h33, 1'b0, 1'b1, "R9 protected mismatch");

    // R12 upper address bits ignored
    for (int ub = 0; ub < 4; ub++) begin
      sendEnable(2'(ub), "R12 prefix");
      doWrite({2'(ub), 15'h00040}, 8'(ub + 8'h70), 1'b1, 1'b0, "R12 data");
      idleWatch(GAP + 4, 0, "R12 window");
      busyPulse(1'b1, 1'b1, "R12 stays on");
    end

    // R8 disable
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R8 d1");
    doWrite(17'h02AAA, 8'h55, 1'b0, 1'b0, "R8 d2");
    doWrite(17'h05555, 8'h80, 1'b0, 1'b0, "R8 d3");
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R8 d4");
    doWrite(17'h02AAA, 8'h55, 1'b0, 1'b0, "R8 d5");
    doWrite(17'h05555, 8'h20, 1'b0, 1'b0, "R8 d6");
    doWrite(17'h00500, 8'hC3, 1'b1, 1'b0, "R8 data");
    idleWatch(GAP + 4, 0, "R8 window");
    busyPulse(1'b1, 1'b0, "R8 disable");

    // R9 mismatch while unprotected
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R9 held off");
    doWrite(17'h00003, 8'h12, 1'b1, 1'b0, "R9 unprotected mismatch");

    // R10 gap abort
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, "R10 k1");
    doWrite(17'h02AAA, 8'h55, 1'b0, 1'b0, "R10 k2");
    idleWatch(GAP + 4, 0, "R10 gap");
    doWrite(17'h05555, 8'hA0, 1'b1, 1'b0, "R10 after abort");
    idleWatch(GAP + 4, 0, "R10 no window");
    busyPulse(1'b0, 1'b0, "R10 stays off");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule